// File: doc/BRIEF.md
# ATA PIO Cycle Sequencer for a CompactFlash Card in True IDE Mode

This block sits between a simple memory-style host bus and the 40-pin parallel ATA interface of a CompactFlash card wired for True IDE operation. The host presents one request at a time: an address, a read/write flag and, for writes, a 16-bit word. The block decodes the top address bits into one of two register windows. The primary window serves the taskfile registers. The alternate window serves device control and alternate status. The block then drives a single ATA PIO cycle on the card pins.

Each cycle runs from three programmed clock counts: strobe setup, strobe pulse and total cycle length. Chip select is framed inside the cycle so that the strobe always lies within it. The device's ready line can stretch the strobe. Read data is taken at the instant the read strobe releases. Only the data register moves 16 bits. Every other register uses the low byte, which keeps each register at an even host address.

The host interface uses a valid/ready handshake. Once the host raises `req_valid`, it must hold `req_valid`, `req_write`, `req_addr` and `req_wdata` steady until it sees `req_ready` high at a clock edge. `req_ready` is the only form of back-pressure. It stays low for the whole ATA cycle, including recovery. It rises for exactly one clock when the cycle ends, and `rsp_rdata` and `rsp_err` are valid in that same clock. A request outside both windows is answered in the clock it appears.

Top module: `pata_pio_engine`

## Requirements
- R1: A request with address bits [23:21] = 3'b110 drives `ata_cs0_n` low and keeps `ata_cs1_n` high while its chip select is active.
- R2: A request with address bits [23:21] = 3'b111 drives `ata_cs1_n` low and keeps `ata_cs0_n` high. The two chip selects are never low together.
- R3: `ata_da` carries host address bits [3:1] during the cycle. Host address bit 0 and bits [20:4] have no effect.
- R4: The data register (primary window, `ata_da` = 0) moves all 16 bits. Every other register moves only bits [7:0]: a write drives 0 on bits [15:8], and a read returns 0 on bits [15:8].
- R5: Let t = 0 be the clock after acceptance. The strobe is low for t in [S, S+P-1] and chip select is low for t in [1, C-2]. S and P are the programmed setup and pulse counts raised to at least 1. C is the programmed cycle count raised to at least S+P+2.
- R6: Read data is the value on `ata_dd_i` in the last clock that `ata_dior_n` is low.
- R7: A write uses the same timeline as a read, with `ata_diow_n` as its strobe, and leaves `ata_dior_n` high. The two strobes are never low together.
- R8: While a strobe is low and `ata_iordy` is low, the strobe stays low in the next clock. A held final pulse clock delays the rest of the cycle by one clock for each held clock.
- R9: `req_ready` is high only in the clock where t = C-1 (plus any stretch), so an accepted request sees C+1 clocks of `req_valid` including the ready clock. `rsp_rdata` and `rsp_err` are valid in that clock.
- R10: `ata_dd_oe` is high only during a write while chip select is low.
- R11: A request whose address bits [23:21] are neither 3'b110 nor 3'b111 gets `req_ready` and `rsp_err` high in the same clock, and produces no chip select or strobe.
- R12: The cycle counts are sampled when a request is accepted. Changing them during the cycle has no effect on that cycle.
- R13: After reset, both chip selects and both strobes are high, `ata_dd_oe` is low and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cycle | input | CNT_W | Programmed total cycle length in clocks |
| cfg_setup | input | CNT_W | Programmed strobe setup in clocks |
| cfg_pulse | input | CNT_W | Programmed strobe pulse in clocks |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request completed this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Host byte address |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Read data, valid with req_ready |
| rsp_err | output | 1 | Address outside both windows, valid with req_ready |
| ata_cs0_n | output | 1 | Primary chip select, active low |
| ata_cs1_n | output | 1 | Alternate chip select, active low |
| ata_da | output | 3 | ATA register address |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dd_o | output | DATA_W | Data driven to the card |
| ata_dd_oe | output | 1 | Output enable for ata_dd_o |
| ata_dd_i | input | DATA_W | Data returned by the card |
| ata_iordy | input | 1 | Device ready, low stretches the strobe |

## Verification
Reads and writes are run in both windows, on the data register and on byte registers. Byte registers are given high-byte data that must not appear, which separates 16-bit handling from 8-bit handling. Several timing programs are applied, including all-zero counts and a cycle count too short for setup plus pulse. The measured chip-select and strobe spans are compared against the clamped timeline. A read device model drives valid data only while the read strobe is low, so a design that captures too late is caught. Other checks cover ready stalls that do and do not reach the final pulse clock, a reprogramming of the counts mid-cycle, an odd address, and addresses outside both windows, which tell the error path apart from a normal completion.

// File: rtl/pata_pio_pkg.sv
package pata_pio_pkg;
  localparam int unsigned WSEL_W   = 3;
  localparam logic [2:0]  PRI_CODE = 3'b110;
  localparam logic [2:0]  ALT_CODE = 3'b111;
  localparam int unsigned DA_W     = 3;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_PRI  = 2'd1,
    WIN_ALT  = 2'd2
  } win_e;

  typedef struct packed {
    win_e            win;
    logic [DA_W-1:0] da;
    logic            wide;
  } dec_t;
endpackage

// File: rtl/pata_win_decode.sv
module pata_win_decode
  import pata_pio_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  localparam int SEL_LO = ADDR_W - WSEL_W;

  logic [WSEL_W-1:0] sel;
  logic              unused_bits;

  assign sel         = addr[ADDR_W-1:SEL_LO];
  assign unused_bits = ^{addr[SEL_LO-1:4], addr[0]};

  always_comb begin
    dec.da = addr[3:1];
    if (sel == PRI_CODE)      dec.win = WIN_PRI;
    else if (sel == ALT_CODE) dec.win = WIN_ALT;
    else                      dec.win = WIN_NONE;
    dec.wide = (dec.win == WIN_PRI) && (addr[3:1] == 3'd0);
  end
endmodule

// File: rtl/pata_cycle_timer.sv
module pata_cycle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cfg_cycle,
  input  logic [CNT_W-1:0] cfg_setup,
  input  logic [CNT_W-1:0] cfg_pulse,
  input  logic             iordy,
  output logic             busy,
  output logic             cs_on,
  output logic             strb_on,
  output logic             sample,
  output logic             done
);
  localparam int TW = CNT_W + 2;
  typedef logic [TW-1:0] tcnt_t;

  tcnt_t s_eff, p_eff, c_eff, c_min;
  tcnt_t s_q, p_q, c_q, t_q, strb_end;
  logic  busy_q, last_pulse, hold;

  always_comb begin
    s_eff = (cfg_setup == '0) ? tcnt_t'(1) : tcnt_t'(cfg_setup);
    p_eff = (cfg_pulse == '0) ? tcnt_t'(1) : tcnt_t'(cfg_pulse);
    c_min = s_eff + p_eff + tcnt_t'(2);
    c_eff = (tcnt_t'(cfg_cycle) < c_min) ? c_min : tcnt_t'(cfg_cycle);
  end

  assign strb_end   = s_q + p_q;
  assign busy       = busy_q;
  assign cs_on      = busy_q && (t_q != '0) && (t_q <= c_q - tcnt_t'(2));
  assign strb_on    = busy_q && (t_q >= s_q) && (t_q < strb_end);
  assign last_pulse = busy_q && (t_q == strb_end - tcnt_t'(1));
  assign hold       = last_pulse && !iordy;
  assign sample     = last_pulse && iordy;
  assign done       = busy_q && (t_q == c_q - tcnt_t'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      t_q    <= '0;
      s_q    <= '0;
      p_q    <= '0;
      c_q    <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        t_q    <= '0;
        s_q    <= s_eff;
        p_q    <= p_eff;
        c_q    <= c_eff;
      end
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (!hold) begin
      t_q <= t_q + tcnt_t'(1);
    end
  end
endmodule

// File: rtl/pata_bus_drive.sv
module pata_bus_drive
  import pata_pio_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  dec_t              dec_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cs_on,
  input  logic              strb_on,
  input  logic              sample,
  input  logic [DATA_W-1:0] dd_i,
  output logic              cs0_n,
  output logic              cs1_n,
  output logic [DA_W-1:0]   da,
  output logic              dior_n,
  output logic              diow_n,
  output logic [DATA_W-1:0] dd_o,
  output logic              dd_oe,
  output logic [DATA_W-1:0] rdata
);
  localparam int LANES = DATA_W / 8;

  win_e              win_q;
  logic [DA_W-1:0]   da_q;
  logic              wide_q, wr_q;
  logic [DATA_W-1:0] wd_q, rd_q, wd_nx, rd_nx;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam bit LOW = (g == 0);
    assign wd_nx[g*8 +: 8] = (LOW || dec_i.wide) ? wdata_i[g*8 +: 8] : 8'h00;
    assign rd_nx[g*8 +: 8] = (LOW || wide_q)     ? dd_i[g*8 +: 8]    : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= WIN_NONE;
      da_q   <= '0;
      wide_q <= 1'b0;
      wr_q   <= 1'b0;
      wd_q   <= '0;
      rd_q   <= '0;
    end else begin
      if (accept) begin
        win_q  <= dec_i.win;
        da_q   <= dec_i.da;
        wide_q <= dec_i.wide;
        wr_q   <= write_i;
        wd_q   <= wd_nx;
      end
      if (sample && !wr_q) rd_q <= rd_nx;
    end
  end

  assign cs0_n  = !(cs_on && (win_q == WIN_PRI));
  assign cs1_n  = !(cs_on && (win_q == WIN_ALT));
  assign da     = da_q;
  assign dior_n = !(strb_on && !wr_q);
  assign diow_n = !(strb_on && wr_q);
  assign dd_o   = wd_q;
  assign dd_oe  = cs_on && wr_q;
  assign rdata  = rd_q;
endmodule

// File: rtl/pata_pio_engine.sv
module pata_pio_engine
  import pata_pio_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_cycle,
  input  logic [CNT_W-1:0]  cfg_setup,
  input  logic [CNT_W-1:0]  cfg_pulse,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              ata_cs0_n,
  output logic              ata_cs1_n,
  output logic [2:0]        ata_da,
  output logic              ata_dior_n,
  output logic              ata_diow_n,
  output logic [DATA_W-1:0] ata_dd_o,
  output logic              ata_dd_oe,
  input  logic [DATA_W-1:0] ata_dd_i,
  input  logic              ata_iordy
);
  dec_t dec;
  logic busy, cs_on, strb_on, sample, done;
  logic accept, miss;

  pata_win_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (req_addr),
    .dec  (dec)
  );

  assign accept    = req_valid && !busy && (dec.win != WIN_NONE);
  assign miss      = req_valid && !busy && (dec.win == WIN_NONE);
  assign req_ready = done || miss;
  assign rsp_err   = miss;

  pata_cycle_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .cfg_cycle (cfg_cycle),
    .cfg_setup (cfg_setup),
    .cfg_pulse (cfg_pulse),
    .iordy     (ata_iordy),
    .busy      (busy),
    .cs_on     (cs_on),
    .strb_on   (strb_on),
    .sample    (sample),
    .done      (done)
  );

  pata_bus_drive #(.DATA_W(DATA_W)) u_drv (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .dec_i   (dec),
    .write_i (req_write),
    .wdata_i (req_wdata),
    .cs_on   (cs_on),
    .strb_on (strb_on),
    .sample  (sample),
    .dd_i    (ata_dd_i),
    .cs0_n   (ata_cs0_n),
    .cs1_n   (ata_cs1_n),
    .da      (ata_da),
    .dior_n  (ata_dior_n),
    .diow_n  (ata_diow_n),
    .dd_o    (ata_dd_o),
    .dd_oe   (ata_dd_oe),
    .rdata   (rsp_rdata)
  );
endmodule

// File: rtl/pata_pio_chk.sv
module pata_pio_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_err,
  input logic ata_cs0_n,
  input logic ata_cs1_n,
  input logic ata_dior_n,
  input logic ata_diow_n,
  input logic ata_dd_oe,
  input logic ata_iordy
);
  assert_cs_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ata_cs0_n || ata_cs1_n);

  assert_strobe_inside_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ata_dior_n || !ata_diow_n) |-> (!ata_cs0_n || !ata_cs1_n));

  assert_strobe_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ata_dior_n || ata_diow_n);

  assert_iordy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((!ata_dior_n || !ata_diow_n) && !ata_iordy) |=> ($stable(ata_dior_n) && $stable(ata_diow_n)));

  assert_ready_with_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid);

  assert_oe_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ata_dd_oe |-> (ata_dior_n && (!ata_cs0_n || !ata_cs1_n)));

  assert_miss_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && rsp_err) |-> (ata_cs0_n && ata_cs1_n && ata_dior_n && ata_diow_n));
endmodule

bind pata_pio_engine pata_pio_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_err    (rsp_err),
  .ata_cs0_n  (ata_cs0_n),
  .ata_cs1_n  (ata_cs1_n),
  .ata_dior_n (ata_dior_n),
  .ata_diow_n (ata_diow_n),
  .ata_dd_oe  (ata_dd_oe),
  .ata_iordy  (ata_iordy)
);

// File: tb/test_pata_pio_engine.sv
`timescale 1ns/1ps
module test_pata_pio_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_cycle = 8'd10, cfg_setup = 8'd2, cfg_pulse = 8'd3;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_err;
  logic [15:0] rsp_rdata;
  logic        ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, ata_dd_oe;
  logic [2:0]  ata_da;
  logic [15:0] ata_dd_o, ata_dd_i;
  logic        ata_iordy = 1'b1;

  always #2.5 clk = ~clk;

  pata_pio_engine i_pata_pio_engine (
    .clk(clk), .rst_n(rst_n), .cfg_cycle(cfg_cycle), .cfg_setup(cfg_setup),
    .cfg_pulse(cfg_pulse), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .ata_cs0_n(ata_cs0_n),
    .ata_cs1_n(ata_cs1_n), .ata_da(ata_da), .ata_dior_n(ata_dior_n),
    .ata_diow_n(ata_diow_n), .ata_dd_o(ata_dd_o), .ata_dd_oe(ata_dd_oe),
    .ata_dd_i(ata_dd_i), .ata_iordy(ata_iordy)
  );

  int n_vec = 0;
  int n_bad = 0;

  typedef struct { logic [15:0] rd; bit err; bit chk_rd; string req; } exp_t;
  exp_t exp_q[$];

  // device model: data valid only while the read strobe is low
  logic [15:0] dev_rd = '0;
  logic [15:0] wcap = '0;
  int          stall_left = 0;
  assign ata_dd_i = !ata_dior_n ? dev_rd : 16'hBAD0;

  always @(negedge clk) begin
    if ((!ata_dior_n || !ata_diow_n) && stall_left > 0) begin
      ata_iordy = 1'b0;
      stall_left--;
    end else begin
      ata_iordy = 1'b1;
    end
    if (!ata_diow_n) wcap = ata_dd_o;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // monitor: pops scoreboard items on each completed handshake
  always @(negedge clk) begin
    #2;
    if (rst_n && req_valid && req_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9", "unexpected completion", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rsp_err == e.err, "R11", "rsp_err", {31'd0, rsp_err}, {31'd0, e.err});
        if (e.chk_rd)
          chk(rsp_rdata == e.rd, e.req, "read data", {16'd0, rsp_rdata}, {16'd0, e.rd});
      end
    end
  end

  task automatic op(input bit wr, input logic [23:0] a, input logic [15:0] wd,
                    input logic [15:0] devv, input int stall,
                    input int c, input int s, input int p, input bit scramble);
    int se, pe, ce, ext, idx, cs_first, cs_cnt, st_first, st_cnt;
    bit miss, pri, wide, win_bad, da_bad, oe_bad, other_bad;
    exp_t e;
    miss = (a[23:21] != 3'b110) && (a[23:21] != 3'b111);
    pri  = (a[23:21] == 3'b110);
    wide = pri && (a[3:1] == 3'd0);
    se   = (s == 0) ? 1 : s;
    pe   = (p == 0) ? 1 : p;
    ce   = (c < se + pe + 2) ? se + pe + 2 : c;
    ext  = (stall - (pe - 1) > 0) ? stall - (pe - 1) : 0;
    e.rd = wide ? devv : {8'h00, devv[7:0]};
    e.err = miss;
    e.chk_rd = !wr && !miss;
    e.req = wide ? "R6" : "R4";
    exp_q.push_back(e);
    cs_first = -1; cs_cnt = 0; st_first = -1; st_cnt = 0;
    win_bad = 0; da_bad = 0; oe_bad = 0; other_bad = 0;
    @(negedge clk);
    cfg_cycle = 8'(c); cfg_setup = 8'(s); cfg_pulse = 8'(p);
    req_write = wr; req_addr = a; req_wdata = wd;
    dev_rd = devv; stall_left = stall; wcap = 16'h0000;
    req_valid = 1'b1;
    idx = 0;
    forever begin
      #1;
      if (!ata_cs0_n || !ata_cs1_n) begin
        if (cs_first < 0) cs_first = idx;
        cs_cnt++;
        if (pri ? (ata_cs0_n || !ata_cs1_n) : (!ata_cs0_n || ata_cs1_n)) win_bad = 1;
        if (ata_da != a[3:1]) da_bad = 1;
      end
      if (wr ? !ata_diow_n : !ata_dior_n) begin
        if (st_first < 0) st_first = idx;
        st_cnt++;
      end
      if (wr ? !ata_dior_n : !ata_diow_n) other_bad = 1;
      if (ata_dd_oe != (wr && (!ata_cs0_n || !ata_cs1_n))) oe_bad = 1;
      if (req_ready || idx > 1000) break;
      @(negedge clk);
      idx++;
      if (scramble && idx == 2) begin
        cfg_cycle = 8'd40; cfg_setup = 8'd9; cfg_pulse = 8'd9;
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (miss) begin
      chk(idx == 0, "R11", "miss latency", idx, 0);
      chk(cs_cnt == 0 && st_cnt == 0, "R11", "bus activity", cs_cnt + st_cnt, 0);
    end else begin
      chk(idx == ce + ext, scramble ? "R12" : "R9", "ready clock", idx, ce + ext);
      chk(cs_first == 2 && cs_cnt == ce - 2 + ext, "R5", "cs span",
          {cs_first[15:0], cs_cnt[15:0]}, {16'd2, 16'(ce - 2 + ext)});
      chk(st_first == se + 1 && st_cnt == pe + ext, stall > 0 ? "R8" : "R5", "strobe span",
          {st_first[15:0], st_cnt[15:0]}, {16'(se + 1), 16'(pe + ext)});
      chk(!win_bad, pri ? "R1" : "R2", "chip select window", win_bad, 0);
      chk(!da_bad, "R3", "register address", da_bad, 0);
      chk(!oe_bad, "R10", "output enable", oe_bad, 0);
      chk(!other_bad, "R7", "wrong strobe", other_bad, 0);
      if (wr) chk(wcap == (wide ? wd : {8'h00, wd[7:0]}), "R4", "write data",
                  wcap, wide ? wd : {8'h00, wd[7:0]});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(ata_cs0_n && ata_cs1_n && ata_dior_n && ata_diow_n && !ata_dd_oe && !req_ready,
        "R13", "reset pins", {ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, ata_dd_oe, req_ready},
        6'b111100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    op(0, 24'hC00000, 16'h0000, 16'hA55A, 0, 10, 2, 3, 0); // R6 wide read
    op(0, 24'hC0000E, 16'h0000, 16'h12F3, 0, 10, 2, 3, 0); // R4 byte read
    op(1, 24'hC00000, 16'hBEEF, 16'h0000, 0, 8, 1, 2, 0);  // R7 wide write
    op(1, 24'hC0000E, 16'h12EC, 16'h0000, 0, 8, 1, 2, 0);  // R4 byte write
    op(0, 24'hE0000C, 16'h0000, 16'h7750, 0, 9, 2, 2, 0);  // R2 alternate read
    op(1, 24'hE0000C, 16'h0A06, 16'h0000, 0, 9, 2, 2, 0);  // R2 alternate write
    op(0, 24'hC00004, 16'h0000, 16'h3311, 0, 0, 0, 0, 0);  // R5 all-zero counts
    op(0, 24'hC00006, 16'h0000, 16'h4422, 0, 5, 3, 4, 0);  // R5 cycle raised
    op(0, 24'hC00000, 16'h0000, 16'hC3C3, 5, 10, 2, 2, 0); // R8 stretched read
    op(1, 24'hC00002, 16'h5A01, 16'h0000, 3, 6, 1, 1, 0);  // R8 stretched write
    op(0, 24'hC00000, 16'h0000, 16'h9999, 1, 10, 2, 3, 0); // R8 stall ends before last pulse
    op(0, 24'h400000, 16'h0000, 16'h0000, 0, 10, 2, 3, 0); // R11
    op(1, 24'h000010, 16'hFFFF, 16'h0000, 0, 10, 2, 3, 0); // R11
    op(0, 24'hC00004, 16'h0000, 16'h6B6B, 0, 12, 3, 4, 1); // R12 mid-cycle change
    op(0, 24'hDFFF05, 16'h0000, 16'hFE81, 0, 7, 1, 2, 0);  // R3 odd address, high bits
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "scoreboard drained", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule